// File: doc/BRIEF.md
# Fixed-Point Multiply-Accumulate Unit with Selectable Rounding

This block is the arithmetic core of a filter inner loop. On every cycle that carries a valid operand pair, it multiplies two signed fractional words and folds the product into a wide accumulator, either adding or subtracting it. Each operand has its sign bit in front of the radix point, so it covers the range from -1 up to just below +1. The accumulator holds the full-precision product plus a band of guard bits. This lets a long run of products build up without intermediate overflow.

A combinational store path reduces the accumulator to a single operand-width word. It offers a choice of truncation, round-to-nearest with ties going up, or convergent rounding with ties going to even. When saturation is on, a value that does not fit is clamped to the largest or smallest representable word. When saturation is off, the value wraps. A sticky flag records that a clamp took place. A clear control restarts the accumulation: it either loads the current product directly or empties the accumulator. The block has no state machine. Its only state is the accumulator register and the sticky flag.

Top module: `fxmac_core`

## Requirements
- R1: The product is the signed OPW x OPW product shifted left by one bit, in 2*OPW bits. The one case where both operands are the most negative value yields the largest positive 2*OPW-bit value instead.
- R2: With `in_vld`=1 and `acc_clr`=0, the accumulator takes the value acc+product on the next edge when `sub_sel`=0, and acc-product when `sub_sel`=1.
- R3: With `in_vld`=1 and `acc_clr`=1, the accumulator loads +product (or -product when `sub_sel`=1). With `acc_clr`=1 alone, it loads zero. With both low, it holds its value.
- R4: The accumulator is 2*OPW+GRD bits wide, and it wraps modulo 2^(2*OPW+GRD) when a sum leaves that range.
- R5: With `rnd_sel`=0, the narrowed value is floor(acc / 2^OPW).
- R6: With `rnd_sel`=1, the narrowed value is floor((acc + 2^(OPW-1)) / 2^OPW). An exact half therefore rounds toward positive.
- R7: With `rnd_sel`=2, the rounding is convergent. Let r be the dropped low part. If r is below half, the value rounds down. If r is above half, it rounds up. If r is exactly half, it rounds up only when the kept LSB is 1, so the result LSB becomes 0.
- R8: `rnd_sel`=3 behaves exactly like truncation.
- R9: With `sat_en`=1, a rounded value above 2^(OPW-1)-1 gives `res_q`=2^(OPW-1)-1, and one below -2^(OPW-1) gives -2^(OPW-1). With `sat_en`=0, `res_q` is the low OPW bits of the rounded value.
- R10: `ovf_q` sets on the edge after a cycle in which `sat_en`=1 and the rounded value was out of range. It then stays set until `acc_clr` is sampled high, which clears it and takes priority.
- R11: After reset, the accumulator is zero and `ovf_q` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Operand pair valid this cycle |
| acc_clr | input | 1 | Restart accumulation; also clears the sticky flag |
| sub_sel | input | 1 | 1 subtracts the product, 0 adds it |
| rnd_sel | input | 2 | Rounding: 0 truncate, 1 nearest, 2 convergent, 3 truncate |
| sat_en | input | 1 | Clamp out-of-range narrowed results |
| opa | input | OPW | Signed fractional operand A |
| opb | input | OPW | Signed fractional operand B |
| acc_q | output | 2*OPW+GRD | Accumulator value |
| res_q | output | OPW | Rounded and narrowed accumulator |
| ovf_q | output | 1 | Sticky saturation indicator |

## Verification
The hardest cases to reach from the ports are the exact-half ties, because they depend on the parity of the kept LSB. Convergent and nearest rounding diverge only in those cases. The bench gets there by loading every one of the 256 possible products of a 4-bit configuration into the accumulator. After each load, it holds the accumulator while stepping through all four rounding codes and both saturation settings. Wrap through the guard band and the sticky flag come from repeated accumulation of the clamped most-negative-squared product and from a long random add/subtract walk with occasional clears.

// File: rtl/fxmac_pkg.sv
package fxmac_pkg;
    typedef enum logic [1:0] {
        RND_TRUNC = 2'd0,
        RND_NEAR  = 2'd1,
        RND_CONV  = 2'd2,
        RND_RSV   = 2'd3
    } rnd_e;
endpackage

// File: rtl/fxmac_mul.sv
module fxmac_mul #(
    parameter int OPW = 16
) (
    input  logic signed [OPW-1:0]   a_i,
    input  logic signed [OPW-1:0]   b_i,
    output logic signed [2*OPW-1:0] prod_o,
    output logic                    clamp_o
);
    localparam int PRW = 2 * OPW;
    localparam logic signed [OPW-1:0] MINV = {1'b1, {(OPW-1){1'b0}}};
    localparam logic signed [PRW-1:0] PMAX = {1'b0, {(PRW-1){1'b1}}};

    logic signed [PRW-1:0] raw;

    always_comb begin
        raw     = PRW'(a_i) * PRW'(b_i);
        clamp_o = (a_i == MINV) && (b_i == MINV);
        if (clamp_o) prod_o = PMAX;
        else         prod_o = raw <<< 1;
    end
endmodule

// File: rtl/fxmac_acc.sv
module fxmac_acc #(
    parameter int PRW = 32,
    parameter int ACW = 40
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_vld,
    input  logic                  acc_clr,
    input  logic                  sub_sel,
    input  logic signed [PRW-1:0] prod_i,
    output logic signed [ACW-1:0] acc_o
);
    logic signed [ACW-1:0] ext;
    logic signed [ACW-1:0] term;

    always_comb begin
        ext  = ACW'(prod_i);
        term = sub_sel ? -ext : ext;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       acc_o <= '0;
        else if (in_vld)  acc_o <= acc_clr ? term : acc_o + term;
        else if (acc_clr) acc_o <= '0;
    end

    AST_ACC_ADD: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld && !acc_clr && !sub_sel |=> acc_o == $past(acc_o) + $past(ext)); // R2
    AST_ACC_SUB: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld && !acc_clr && sub_sel |=> acc_o == $past(acc_o) - $past(ext)); // R2
    AST_CLR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        acc_clr && !in_vld |=> acc_o == '0); // R3
    AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_clr && !in_vld |=> $stable(acc_o)); // R3
endmodule

// File: rtl/fxmac_narrow.sv
module fxmac_narrow
    import fxmac_pkg::*;
#(
    parameter int OPW = 16,
    parameter int ACW = 40
) (
    input  logic signed [ACW-1:0] acc_i,
    input  rnd_e                  mode_i,
    input  logic                  sat_en,
    output logic signed [OPW-1:0] res_o,
    output logic                  clip_o
);
    localparam int QW = ACW - OPW + 1;
    localparam logic [OPW-1:0] HALF = {1'b1, {(OPW-1){1'b0}}};
    localparam logic signed [QW-1:0] MAXR = {{(QW-OPW+1){1'b0}}, {(OPW-1){1'b1}}};
    localparam logic signed [QW-1:0] MINR = {{(QW-OPW+1){1'b1}}, {(OPW-1){1'b0}}};
    localparam logic signed [OPW-1:0] MAXN = {1'b0, {(OPW-1){1'b1}}};
    localparam logic signed [OPW-1:0] MINN = {1'b1, {(OPW-1){1'b0}}};

    logic [OPW-1:0]        frac;
    logic signed [QW-1:0]  base;
    logic signed [QW-1:0]  q;
    logic                  up;
    logic                  hi;
    logic                  lo;

    always_comb begin
        frac = acc_i[OPW-1:0];
        base = QW'(acc_i >>> OPW);
        unique case (mode_i)
            RND_NEAR:           up = frac[OPW-1];
            RND_CONV:           up = (frac > HALF) || ((frac == HALF) && base[0]);
            RND_TRUNC, RND_RSV: up = 1'b0;
            default:            up = 1'b0;
        endcase
        q      = base + $signed({{(QW-1){1'b0}}, up});
        hi     = q > MAXR;
        lo     = q < MINR;
        clip_o = sat_en && (hi || lo);
        if (sat_en && hi)      res_o = MAXN;
        else if (sat_en && lo) res_o = MINN;
        else                   res_o = q[OPW-1:0];
    end
endmodule

// File: rtl/fxmac_core.sv
module fxmac_core
    import fxmac_pkg::*;
#(
    parameter int OPW = 16,
    parameter int GRD = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_vld,
    input  logic                        acc_clr,
    input  logic                        sub_sel,
    input  logic [1:0]                  rnd_sel,
    input  logic                        sat_en,
    input  logic signed [OPW-1:0]       opa,
    input  logic signed [OPW-1:0]       opb,
    output logic signed [2*OPW+GRD-1:0] acc_q,
    output logic signed [OPW-1:0]       res_q,
    output logic                        ovf_q
);
    localparam int PRW = 2 * OPW;
    localparam int ACW = PRW + GRD;
    localparam logic signed [OPW-1:0] MAXN = {1'b0, {(OPW-1){1'b1}}};
    localparam logic signed [OPW-1:0] MINN = {1'b1, {(OPW-1){1'b0}}};

    logic signed [PRW-1:0] prod;
    logic                  prod_clamp;
    logic                  clip;
    rnd_e                  mode;

    assign mode = rnd_e'(rnd_sel);

    fxmac_mul #(.OPW(OPW)) i_mul (
        .a_i     (opa),
        .b_i     (opb),
        .prod_o  (prod),
        .clamp_o (prod_clamp)
    );

    fxmac_acc #(.PRW(PRW), .ACW(ACW)) i_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (in_vld),
        .acc_clr (acc_clr),
        .sub_sel (sub_sel),
        .prod_i  (prod),
        .acc_o   (acc_q)
    );

    fxmac_narrow #(.OPW(OPW), .ACW(ACW)) i_narrow (
        .acc_i  (acc_q),
        .mode_i (mode),
        .sat_en (sat_en),
        .res_o  (res_q),
        .clip_o (clip)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ovf_q <= 1'b0;
        else if (acc_clr) ovf_q <= 1'b0;
        else if (clip)    ovf_q <= 1'b1;
    end

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q && !acc_clr |=> ovf_q); // R10
    AST_OVF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        acc_clr |=> !ovf_q); // R10
    AST_SAT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        clip |-> (res_q == MAXN) || (res_q == MINN)); // R9
    AST_PROD_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        prod_clamp |-> !prod[PRW-1]); // R1
endmodule

// File: tb/test_fxmac_core.sv
module test_fxmac_core;
    localparam int N  = 4;
    localparam int G  = 2;
    localparam int AW = 2 * N + G;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_vld = 1'b0;
    logic acc_clr = 1'b0;
    logic sub_sel = 1'b0;
    logic [1:0] rnd_sel = 2'd0;
    logic sat_en = 1'b0;
    logic signed [N-1:0] opa = '0;
    logic signed [N-1:0] opb = '0;
    logic signed [AW-1:0] acc_q;
    logic signed [N-1:0] res_q;
    logic ovf_q;

    int n_chk = 0;
    int n_bad = 0;
    int acc_m = 0;
    bit ovf_m = 1'b0;

    always #10 clk = ~clk;

    fxmac_core #(.OPW(N), .GRD(G)) i_fxmac_core (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .acc_clr(acc_clr),
        .sub_sel(sub_sel), .rnd_sel(rnd_sel), .sat_en(sat_en),
        .opa(opa), .opb(opb), .acc_q(acc_q), .res_q(res_q), .ovf_q(ovf_q)
    );

    function automatic int wrap_acc(int v);
        int m = v % 1024;
        if (m < 0) m += 1024;
        if (m >= 512) m -= 1024;
        return m;
    endfunction

    function automatic int prod_m(int a, int b);
        int p = a * b * 2;
        if (p == 128) p = 127;
        return p;
    endfunction

    function automatic int fdiv16(int v);
        if (v >= 0) return v / 16;
        return -((-v + 15) / 16);
    endfunction

    function automatic int rnd_m(int v, int mode);
        int q;
        int r;
        case (mode)
            1: q = fdiv16(v + 8);
            2: begin
                q = fdiv16(v);
                r = v - 16 * q;
                if (r > 8 || (r == 8 && (q % 2 != 0))) q = q + 1;
            end
            default: q = fdiv16(v);
        endcase
        return q;
    endfunction

    function automatic int fin_m(int q, bit se);
        int w;
        if (se) begin
            if (q > 7) return 7;
            if (q < -8) return -8;
            return q;
        end
        w = q % 16;
        if (w < 0) w += 16;
        if (w >= 8) w -= 16;
        return w;
    endfunction

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic step(bit v, bit c, bit s, int m, bit se, int a, int b, string tag);
        string rt;
        bit clipped;
        int q;
        int term;
        in_vld = v; acc_clr = c; sub_sel = s; rnd_sel = 2'(m); sat_en = se;
        opa = N'(a); opb = N'(b);
        #1;
        case (m)
            0: rt = "R5";
            1: rt = "R6";
            2: rt = "R7";
            default: rt = "R8";
        endcase
        if (se) rt = {rt, "+R9"};
        q = rnd_m(acc_m, m);
        check(rt, int'(res_q), fin_m(q, se));
        clipped = se && (q > 7 || q < -8);
        @(posedge clk);
        term = s ? -prod_m(a, b) : prod_m(a, b);
        if (v) acc_m = wrap_acc(c ? term : acc_m + term);
        else if (c) acc_m = 0;
        ovf_m = c ? 1'b0 : (ovf_m | clipped);
        @(negedge clk);
        check(tag, int'(acc_q), acc_m);
        check("R10", int'(ovf_q), int'(ovf_m));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R11", int'(acc_q), 0);
        check("R11", int'(ovf_q), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: every product loaded by clear, then held across all modes (R5..R9)
        for (int a = -8; a < 8; a++) begin
            for (int b = -8; b < 8; b++) begin
                step(1, 1, 0, 0, 0, a, b, "R1");
                for (int m = 0; m < 4; m++)
                    for (int se = 0; se < 2; se++)
                        step(0, 0, 0, m, bit'(se), 0, 0, "R3");
            end
        end

        // R3: negated load, then clear alone empties
        step(1, 1, 1, 0, 0, 3, 5, "R3");
        step(0, 0, 0, 0, 0, 0, 0, "R3");
        step(0, 1, 0, 0, 0, 0, 0, "R3");

        // R4: -1 x -1 clamp accumulated until the guard band wraps
        step(1, 1, 0, 0, 0, -8, -8, "R4");
        for (int k = 0; k < 5; k++) step(1, 0, 0, 0, 0, -8, -8, "R4");

        // R10: clamp sets sticky flag, stays with sat off, clears on clear
        step(1, 1, 0, 1, 1, -8, -8, "R10");
        step(0, 0, 0, 1, 1, 0, 0, "R10");
        step(0, 0, 0, 0, 0, 0, 0, "R10");
        step(0, 1, 0, 0, 0, 0, 0, "R10");

        // R2: random add/subtract walk with occasional clears
        for (int k = 0; k < 3000; k++) begin
            int a = int'($urandom_range(15)) - 8;
            int b = int'($urandom_range(15)) - 8;
            bit c = ($urandom_range(15) == 0);
            bit s = bit'($urandom_range(1));
            int m = int'($urandom_range(3));
            bit se = bit'($urandom_range(1));
            step(1, c, s, m, se, a, b, "R2");
            for (int mm = 0; mm < 4; mm++)
                step(0, 0, 0, mm, bit'($urandom_range(1)), 0, 0, "R3");
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(20 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL R11 watchdog act=running exp=finished");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule